// File: doc/BRIEF.md
# Nibble-Masked Packet Pattern Filter

This block classifies received Ethernet frames as their bytes arrive. It holds a set of programmable filters that are all evaluated in parallel against the same byte stream. Each filter is a sequence of pattern words, where each word covers two frame bytes. A mask bit for each 4-bit nibble lets a filter demand exact values in some nibbles and ignore the others. Each filter also has a byte length, an enable bit and a 4-bit destination queue.

Once the frame's fate is settled, the block emits a single result strobe. The strobe carries a hit flag, the index of the winning filter and the queue mapped to it. The frame's fate is settled either by its last byte or by every enabled filter having seen its full length.

Software programs the filters through a flat word-addressed register port. The whole filter set is snapshotted at each start of frame. A frame is therefore judged against one consistent configuration, even when software rewrites it mid-frame.

Top module: `pkt_pattern_filter`

## Requirements
- R1: After reset, no result strobe is issued, and every register reads 0: the global switch, the enables, the lengths, the queue maps and the pattern memory.
- R2: Register map by reg_addr[15:14]. Region 0 holds the global switch in bit 0 of address 0. It also holds two enable words: filters 0–31 use bit i of address 2, and filters 32–63 use bit i−32 of address 1. Region 1 (0x4000+k) holds the length words: filter i's 8-bit length sits in word k=(NUM_FILT−1−i)/4, at bits [8·(i mod 4)+:8]. Region 2 (0x8000+k) holds the queue words: filter i's queue sits in word i/8, at bits [4·(i mod 8)+:4]. Region 3 (0xC000 + i·PAT_WORDS + w) holds pattern word w of filter i. Bits 31:20 of pattern words are not stored and read as 0.
- R3: Pattern word w is compared with frame bytes 2w and 2w+1. The high nibble of byte 2w is compared with bits 15:12, and its low nibble with bits 11:8. The high nibble of byte 2w+1 is compared with bits 7:4, and its low nibble with bits 3:0. Bits 19, 18, 17 and 16 enable those four nibble compares in that order. A nibble whose enable bit is 0 matches any value.
- R4: A filter hits when all of the following hold: the global switch is on, the filter's enable bit is set, its length is non-zero, the frame has at least that many bytes, and every enabled nibble of the bytes below the length matches. Bytes at or beyond the length are not compared. A disabled filter with a matching pattern does not hit.
- R5: A frame that ends before a filter's length is reached is a miss for that filter, even if every byte received so far matched.
- R6: When several filters hit, the lowest-numbered one is reported, together with its queue.
- R7: Each frame gets exactly one result strobe, one cycle after its deciding beat. The deciding beat is the end-of-frame beat, or the beat at which every enabled filter has received its length in bytes, whichever comes first. Later beats of that frame, and beats outside a frame (no start-of-frame seen), produce no strobe.
- R8: Register writes take effect on the frame whose start-of-frame comes after the write. A frame already in progress is judged against the settings that held when its start-of-frame beat arrived.
- R9: A miss is reported with res_hit=0, res_index=0 and res_queue=0. res_hit is 0 whenever res_valid is 0.
- R10: With the global switch off, every frame's result is a miss, strobed one cycle after its start-of-frame beat.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Frame byte valid |
| in_sof | input | 1 | Byte is the first of a frame |
| in_eof | input | 1 | Byte is the last of a frame |
| in_data | input | 8 | Frame byte |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 16 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational, programmed values) |
| res_valid | output | 1 | Result strobe, one cycle per frame |
| res_hit | output | 1 | A filter matched |
| res_index | output | clog2(NUM_FILT) | Winning filter index |
| res_queue | output | 4 | Queue mapped to the winning filter |

## Verification
A table of frames is run against a fixed set of four filters:
- A full-byte match on the first byte.
- A two-byte match at offsets 12–13.
- A masked match where only one nibble in each of two bytes counts.
- An enabled filter of length 0.

The frames separate the following cases:
- An exact hit from a single-nibble mismatch.
- A masked nibble from a compared one.
- A frame that is too short from one that just reaches the length.
- Two simultaneous hits, which show the priority order.

Directed frames then cover the remaining behaviour:
- Enabling a catch-all filter.
- Turning the global switch off.
- A write landing mid-frame.
- Bytes arriving with no start-of-frame.

Across all of these, the exact beat of the strobe is checked, which separates an early decision from an end-of-frame decision.

// File: rtl/ppf_pkg.sv
package ppf_pkg;

    localparam int ADDR_W = 16;

    // Address region selector, reg_addr[15:14]
    localparam logic [1:0] RG_CTRL = 2'b00;
    localparam logic [1:0] RG_LEN  = 2'b01;
    localparam logic [1:0] RG_QMAP = 2'b10;
    localparam logic [1:0] RG_PAT  = 2'b11;

    // Stored pattern word: [19:16] nibble enables, [15:0] nibble data
    typedef logic [19:0] pword_t;

    // Per-filter settings as seen by a compare lane
    typedef struct packed {
        logic       on;
        logic [7:0] len;
        logic [3:0] queue;
    } fcfg_t;

    // Compare one frame byte against its half of a pattern word
    function automatic logic byte_matches(pword_t w, logic odd, logic [7:0] b);
        logic [3:0] hi_d;
        logic [3:0] lo_d;
        logic       hi_e;
        logic       lo_e;
        if (!odd) begin
            hi_d = w[15:12]; lo_d = w[11:8]; hi_e = w[19]; lo_e = w[18];
        end else begin
            hi_d = w[7:4];   lo_d = w[3:0];  hi_e = w[17]; lo_e = w[16];
        end
        return (!hi_e || (hi_d == b[7:4])) && (!lo_e || (lo_d == b[3:0]));
    endfunction

endpackage

// File: rtl/ppf_cfg_store.sv
module ppf_cfg_store
    import ppf_pkg::*;
#(
    parameter int NF = 8,
    parameter int NW = 16
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 we,
    input  logic [ADDR_W-1:0]    addr,
    input  logic [31:0]          wdata,
    output logic [31:0]          rdata,
    input  logic                 load,
    input  logic [7:0]           widx,
    output fcfg_t [NF-1:0]       cfg,
    output pword_t [NF-1:0]      word
);
    localparam int DEPTH = NF * NW;
    localparam int PIW   = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int WIW   = (NW > 1) ? $clog2(NW) : 1;

    logic [1:0]  region;
    logic [13:0] idx;
    assign region = addr[15:14];
    assign idx    = addr[13:0];

    // Programmed (shadow) copy
    logic          sh_glob;
    logic [NF-1:0] sh_en;
    logic [7:0]    sh_len [NF];
    logic [3:0]    sh_q   [NF];
    pword_t        sh_pat [DEPTH];

    // Copy in force for the current frame
    logic          ac_glob;
    logic [NF-1:0] ac_en;
    logic [7:0]    ac_len [NF];
    logic [3:0]    ac_q   [NF];
    pword_t        ac_pat [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            sh_glob <= 1'b0;
            sh_en   <= '0;
            for (int i = 0; i < NF; i++) begin
                sh_len[i] <= '0;
                sh_q[i]   <= '0;
            end
            for (int j = 0; j < DEPTH; j++) sh_pat[j] <= '0;
        end else if (we) begin
            case (region)
                RG_CTRL: begin
                    if (idx == 14'd0) sh_glob <= wdata[0];
                    for (int i = 0; i < NF; i++)
                        if ((i < 32) ? (idx == 14'd2) : (idx == 14'd1))
                            sh_en[i] <= wdata[i % 32];
                end
                RG_LEN: begin
                    for (int i = 0; i < NF; i++)
                        if (idx == 14'((NF - 1 - i) / 4))
                            sh_len[i] <= wdata[8 * (i % 4) +: 8];
                end
                RG_QMAP: begin
                    for (int i = 0; i < NF; i++)
                        if (idx == 14'(i / 8))
                            sh_q[i] <= wdata[4 * (i % 8) +: 4];
                end
                default: begin
                    if (32'(idx) < DEPTH)
                        sh_pat[idx[PIW-1:0]] <= wdata[19:0];
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ac_glob <= 1'b0;
            ac_en   <= '0;
            for (int i = 0; i < NF; i++) begin
                ac_len[i] <= '0;
                ac_q[i]   <= '0;
            end
            for (int j = 0; j < DEPTH; j++) ac_pat[j] <= '0;
        end else if (load) begin
            ac_glob <= sh_glob;
            ac_en   <= sh_en;
            for (int i = 0; i < NF; i++) begin
                ac_len[i] <= sh_len[i];
                ac_q[i]   <= sh_q[i];
            end
            for (int j = 0; j < DEPTH; j++) ac_pat[j] <= sh_pat[j];
        end
    end

    // Read-back of the programmed values
    always_comb begin
        rdata = '0;
        case (region)
            RG_CTRL: begin
                if (idx == 14'd0) rdata[0] = sh_glob;
                for (int i = 0; i < NF; i++)
                    if ((i < 32) ? (idx == 14'd2) : (idx == 14'd1))
                        rdata[i % 32] = sh_en[i];
            end
            RG_LEN: begin
                for (int i = 0; i < NF; i++)
                    if (idx == 14'((NF - 1 - i) / 4))
                        rdata[8 * (i % 4) +: 8] = sh_len[i];
            end
            RG_QMAP: begin
                for (int i = 0; i < NF; i++)
                    if (idx == 14'(i / 8))
                        rdata[4 * (i % 8) +: 4] = sh_q[i];
            end
            default: begin
                if (32'(idx) < DEPTH)
                    rdata[19:0] = sh_pat[idx[PIW-1:0]];
            end
        endcase
    end

    // On the start beat the lanes see the programmed copy directly
    for (genvar f = 0; f < NF; f++) begin : g_sel
        logic [PIW-1:0] pix;
        assign pix = PIW'(f * NW) + PIW'(widx[WIW-1:0]);

        always_comb begin
            if (load) begin
                cfg[f].on    = sh_glob & sh_en[f];
                cfg[f].len   = sh_len[f];
                cfg[f].queue = sh_q[f];
            end else begin
                cfg[f].on    = ac_glob & ac_en[f];
                cfg[f].len   = ac_len[f];
                cfg[f].queue = ac_q[f];
            end
            if (32'(widx) < NW)
                word[f] = load ? sh_pat[pix] : ac_pat[pix];
            else
                word[f] = '0;
        end
    end

endmodule

// File: rtl/ppf_lane.sv
module ppf_lane
    import ppf_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       beat,
    input  logic       start,
    input  fcfg_t      cfg,
    input  pword_t     word,
    input  logic [7:0] data,
    input  logic [8:0] pos,
    input  logic [8:0] recv,
    output logic       hit,
    output logic       passed
);
    logic ok;
    logic ok_n;
    logic in_win;
    logic reached;

    assign in_win  = pos < {1'b0, cfg.len};
    assign reached = recv >= {1'b0, cfg.len};
    assign ok_n    = (start ? 1'b1 : ok) & (!in_win | byte_matches(word, pos[0], data));
    assign hit     = cfg.on & (cfg.len != 8'd0) & ok_n & reached;
    assign passed  = !cfg.on | reached;

    always_ff @(posedge clk) begin
        if (rst)       ok <= 1'b0;
        else if (beat) ok <= ok_n;
    end

endmodule

// File: rtl/ppf_pick.sv
module ppf_pick #(
    parameter int NF = 8,
    parameter int IW = 3
) (
    input  logic [NF-1:0]      hit,
    input  logic [NF-1:0][3:0] qmap,
    output logic               found,
    output logic [IW-1:0]      index,
    output logic [3:0]         queue
);
    always_comb begin
        found = 1'b0;
        index = '0;
        queue = '0;
        for (int i = NF - 1; i >= 0; i--) begin
            if (hit[i]) begin
                found = 1'b1;
                index = IW'(i);
                queue = qmap[i];
            end
        end
    end
endmodule

// File: rtl/pkt_pattern_filter.sv
module pkt_pattern_filter
    import ppf_pkg::*;
#(
    parameter int NUM_FILT  = 8,
    parameter int PAT_WORDS = 16
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        in_valid,
    input  logic                        in_sof,
    input  logic                        in_eof,
    input  logic [7:0]                  in_data,
    input  logic                        reg_we,
    input  logic [15:0]                 reg_addr,
    input  logic [31:0]                 reg_wdata,
    output logic [31:0]                 reg_rdata,
    output logic                        res_valid,
    output logic                        res_hit,
    output logic [$clog2(NUM_FILT)-1:0] res_index,
    output logic [3:0]                  res_queue
);
    localparam int IDX_W = $clog2(NUM_FILT);

    logic                  busy;
    logic [8:0]            cnt;
    logic                  start, beat, done;
    logic [8:0]            pos, recv;
    fcfg_t  [NUM_FILT-1:0] cfg_v;
    pword_t [NUM_FILT-1:0] word_v;
    logic [NUM_FILT-1:0]   hit_v, pass_v;
    logic [NUM_FILT-1:0][3:0] q_v;
    logic                  found;
    logic [IDX_W-1:0]      win_idx;
    logic [3:0]            win_q;

    assign start = in_valid & in_sof;
    assign beat  = in_valid & (in_sof | busy);
    assign pos   = start ? 9'd0 : cnt;
    assign recv  = (pos == 9'd256) ? pos : pos + 9'd1;

    ppf_cfg_store #(.NF(NUM_FILT), .NW(PAT_WORDS)) u_cfg (
        .clk   (clk),
        .rst   (rst),
        .we    (reg_we),
        .addr  (reg_addr),
        .wdata (reg_wdata),
        .rdata (reg_rdata),
        .load  (start),
        .widx  (pos[8:1]),
        .cfg   (cfg_v),
        .word  (word_v)
    );

    for (genvar f = 0; f < NUM_FILT; f++) begin : g_lane
        ppf_lane u_lane (
            .clk    (clk),
            .rst    (rst),
            .beat   (beat),
            .start  (start),
            .cfg    (cfg_v[f]),
            .word   (word_v[f]),
            .data   (in_data),
            .pos    (pos),
            .recv   (recv),
            .hit    (hit_v[f]),
            .passed (pass_v[f])
        );
        assign q_v[f] = cfg_v[f].queue;
    end

    ppf_pick #(.NF(NUM_FILT), .IW(IDX_W)) u_pick (
        .hit   (hit_v),
        .qmap  (q_v),
        .found (found),
        .index (win_idx),
        .queue (win_q)
    );

    assign done = beat & (in_eof | (&pass_v));

    always_ff @(posedge clk) begin
        if (rst) begin
            busy      <= 1'b0;
            cnt       <= '0;
            res_valid <= 1'b0;
            res_hit   <= 1'b0;
            res_index <= '0;
            res_queue <= '0;
        end else begin
            if (beat) begin
                cnt  <= recv;
                busy <= !done;
            end
            res_valid <= done;
            res_hit   <= done & found;
            res_index <= (done & found) ? win_idx : '0;
            res_queue <= (done & found) ? win_q : '0;
        end
    end

endmodule

// File: rtl/ppf_checker.sv
module ppf_checker #(
    parameter int IDX_W = 3
) (
    input logic             clk,
    input logic             rst,
    input logic             in_valid,
    input logic             in_sof,
    input logic             res_valid,
    input logic             res_hit,
    input logic [IDX_W-1:0] res_index,
    input logic [3:0]       res_queue
);
    // Set once a frame's strobe has gone out, cleared by the next start beat
    logic issued;
    always_ff @(posedge clk) begin
        if (rst)                    issued <= 1'b0;
        else if (in_valid && in_sof) issued <= 1'b0;
        else if (res_valid)          issued <= 1'b1;
    end

    a_r7_one_per_frame: assert property (@(posedge clk) disable iff (rst)
        res_valid |-> !issued);

    a_r7_follows_beat: assert property (@(posedge clk) disable iff (rst)
        res_valid |-> $past(in_valid));

    a_r9_hit_needs_valid: assert property (@(posedge clk) disable iff (rst)
        !res_valid |-> !res_hit);

    a_r9_miss_zero: assert property (@(posedge clk) disable iff (rst)
        (res_valid && !res_hit) |-> (res_index == '0 && res_queue == 4'd0));

endmodule

bind pkt_pattern_filter ppf_checker #(.IDX_W($clog2(NUM_FILT))) u_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_sof    (in_sof),
    .res_valid (res_valid),
    .res_hit   (res_hit),
    .res_index (res_index),
    .res_queue (res_queue)
);

// File: tb/tb_pkt_pattern_filter.sv
module tb_pkt_pattern_filter;
    localparam int CLK_P = 10;
    localparam int NF    = 8;
    localparam int NW    = 16;
    localparam int NVEC  = 10;

    // {b0,b1,b2,b3,b12,b13, nbytes, hit, idx[2:0], queue[3:0]}
    localparam logic [63:0] VEC [NVEC] = '{
        {8'hAB, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'd20, 1'b1, 3'd1, 4'd5},
        {8'hAB, 8'h00, 8'h00, 8'h00, 8'h08, 8'h00, 8'd20, 1'b1, 3'd0, 4'd3},
        {8'h00, 8'h00, 8'h4F, 8'h30, 8'h00, 8'h00, 8'd20, 1'b1, 3'd2, 4'd9},
        {8'h00, 8'h00, 8'h4F, 8'h31, 8'h00, 8'h00, 8'd20, 1'b0, 3'd0, 4'd0},
        {8'hAB, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'd1,  1'b0, 3'd0, 4'd0},
        {8'hAB, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'd2,  1'b1, 3'd1, 4'd5},
        {8'h00, 8'h00, 8'h00, 8'h00, 8'h08, 8'h00, 8'd13, 1'b0, 3'd0, 4'd0},
        {8'h00, 8'h00, 8'h00, 8'h00, 8'h08, 8'h01, 8'd14, 1'b0, 3'd0, 4'd0},
        {8'hAC, 8'hFF, 8'h00, 8'h00, 8'h00, 8'h00, 8'd20, 1'b0, 3'd0, 4'd0},
        {8'hAB, 8'h77, 8'h45, 8'h20, 8'h08, 8'h00, 8'd20, 1'b1, 3'd0, 4'd3}
    };

    logic        clk = 1'b0;
    logic        rst;
    logic        in_valid, in_sof, in_eof;
    logic [7:0]  in_data;
    logic        reg_we;
    logic [15:0] reg_addr;
    logic [31:0] reg_wdata;
    logic [31:0] reg_rdata;
    logic        res_valid, res_hit;
    logic [2:0]  res_index;
    logic [3:0]  res_queue;

    int checks = 0;
    int fails  = 0;
    logic [7:0] fr [32];

    always #(CLK_P / 2) clk = ~clk;

    pkt_pattern_filter #(.NUM_FILT(NF), .PAT_WORDS(NW)) dut (
        .clk(clk), .rst(rst),
        .in_valid(in_valid), .in_sof(in_sof), .in_eof(in_eof), .in_data(in_data),
        .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .res_valid(res_valid), .res_hit(res_hit), .res_index(res_index), .res_queue(res_queue)
    );

    task automatic chk_eq(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(logic [15:0] a, logic [31:0] d);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd_chk(logic [15:0] a, logic [31:0] exp, string tag);
        reg_addr = a;
        #1;
        chk_eq(tag, reg_rdata, exp);
        @(negedge clk);
    endtask

    task automatic clear_frame();
        for (int i = 0; i < 32; i++) fr[i] = 8'h00;
    endtask

    // Drive fr[0..n-1]; expect one strobe right after beat expk
    task automatic send_frame(int n, int expk, bit eh, int ei, int eq, string tag,
                              bit mw, logic [15:0] ma, logic [31:0] md);
        int seen = 0;
        for (int i = 0; i < n; i++) begin
            in_valid = 1'b1; in_sof = (i == 0); in_eof = (i == n - 1); in_data = fr[i];
            if (mw && i == 2) begin reg_we = 1'b1; reg_addr = ma; reg_wdata = md; end
            @(negedge clk);
            reg_we = 1'b0;
            if (res_valid) begin
                seen++;
                if (i + 1 == expk) begin
                    chk_eq({tag, " hit"},   32'(res_hit),   32'(eh));
                    chk_eq({tag, " index"}, 32'(res_index), 32'(ei));
                    chk_eq({tag, " queue"}, 32'(res_queue), 32'(eq));
                end else begin
                    chk_eq({tag, " R7 strobe beat"}, 32'(i + 1), 32'(expk));
                end
            end
        end
        in_valid = 1'b0; in_sof = 1'b0; in_eof = 1'b0;
        @(negedge clk);
        if (res_valid) seen++;
        chk_eq({tag, " R7 strobe count"}, 32'(seen), 32'(expk > 0 ? 1 : 0));
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        rst = 1'b1; in_valid = 1'b0; in_sof = 1'b0; in_eof = 1'b0; in_data = '0;
        reg_we = 1'b0; reg_addr = '0; reg_wdata = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        chk_eq("R1 res_valid", 32'(res_valid), 0);
        rd_chk(16'h0000, 32'h0, "R1 global");
        rd_chk(16'h0002, 32'h0, "R1 enables");
        rd_chk(16'h4001, 32'h0, "R1 lengths");
        rd_chk(16'h8000, 32'h0, "R1 queues");
        rd_chk(16'hC006, 32'h0, "R1 pattern");

        // Filter 0: bytes 12-13 = 08 00, len 14, queue 3
        wr(16'hC006, 32'h000F0800);
        // Filter 1: byte 0 = AB, len 2, queue 5
        wr(16'hC010, 32'h000CAB00);
        // Filter 2: byte2 high nibble 4, byte3 low nibble 0, len 4, queue 9 (upper bits junk)
        wr(16'hC021, 32'hFFF94000);
        // Lengths: F0..F3 in word 1 (lanes 0..3), F4..F7 in word 0; F7 length 0
        wr(16'h4001, 32'h0204020E);
        wr(16'h8000, 32'hF0007953);
        wr(16'h0002, 32'h00000087);
        wr(16'h0001, 32'hFFFFFFFF);
        wr(16'h0000, 32'h00000001);

        // R2 read-back and packing
        rd_chk(16'h4001, 32'h0204020E, "R2 length word 1");
        rd_chk(16'h4000, 32'h0, "R2 length word 0");
        rd_chk(16'h8000, 32'hF0007953, "R2 queue word");
        rd_chk(16'h0002, 32'h00000087, "R2 enables 0-31");
        rd_chk(16'h0001, 32'h0, "R2 enables 32-63 absent");
        rd_chk(16'hC021, 32'h00094000, "R2 pattern upper bits");
        rd_chk(16'h0000, 32'h1, "R2 global");

        // Table walk: R3 nibble compare, R4 length window, R5 short frames, R6 priority
        for (int v = 0; v < NVEC; v++) begin
            logic [63:0] e;
            int n;
            e = VEC[v];
            clear_frame();
            fr[0] = e[63:56]; fr[1] = e[55:48]; fr[2] = e[47:40]; fr[3] = e[39:32];
            fr[12] = e[31:24]; fr[13] = e[23:16];
            n = int'(e[15:8]);
            send_frame(n, (n < 14) ? n : 14, e[7], int'(e[6:4]), int'(e[3:0]),
                       $sformatf("R3/R4/R5/R6 vec%0d", v), 1'b0, 16'h0, 32'h0);
        end

        // R7 beats without start-of-frame are ignored
        begin
            int seen = 0;
            for (int i = 0; i < 4; i++) begin
                in_valid = 1'b1; in_sof = 1'b0; in_eof = (i == 3); in_data = 8'hAB;
                @(negedge clk);
                if (res_valid) seen++;
            end
            in_valid = 1'b0; in_eof = 1'b0;
            @(negedge clk);
            if (res_valid) seen++;
            chk_eq("R7 no strobe outside frame", 32'(seen), 0);
        end

        // R4 enabling filter 3 (catch-all, len 2, queue 7)
        clear_frame();
        send_frame(16, 14, 1'b0, 0, 0, "R4 F3 disabled", 1'b0, 16'h0, 32'h0);
        wr(16'h0002, 32'h0000008F);
        send_frame(16, 14, 1'b1, 3, 7, "R4 F3 enabled", 1'b0, 16'h0, 32'h0);
        // R6 filter 1 beats filter 3
        fr[0] = 8'hAB;
        send_frame(16, 14, 1'b1, 1, 5, "R6 F1 over F3", 1'b0, 16'h0, 32'h0);

        // R8 global switched off mid-frame: current frame unaffected
        send_frame(16, 14, 1'b1, 1, 5, "R8 old settings", 1'b1, 16'h0000, 32'h0);
        // R10 next frame sees the switch off: miss right after first beat
        send_frame(16, 1, 1'b0, 0, 0, "R10 global off", 1'b0, 16'h0, 32'h0);
        wr(16'h0000, 32'h00000001);
        send_frame(16, 14, 1'b1, 1, 5, "R8 global back on", 1'b0, 16'h0, 32'h0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule